// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset and one of four 16-bit segment bases into a 20-bit physical address, the way real-mode segmentation does: the base is moved up by one hex digit (four zero bits appended) and the offset is added, with the sum kept to 20 bits. The four bases (code, data, extra, stack) live in registers that a write port loads.

Each request names an access kind and, for data accesses, the base register that formed the offset. From these the block chooses the segment by the fixed pairing rules. An override input can replace that choice for every kind except the string destination. For string elements the block also holds the source and destination index pointers. It uses the relevant pointer as the offset and then moves it by the element size, up or down as the direction input selects.

The address, and the code of the segment that was used, appear one clock after the request strobe together with a valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `addr_valid` is 0 and both index pointers read 0. All four segment bases are 0, so a request returns its own offset as the address.
- R2: A request captured on a rising edge drives `phys_addr = ({seg,4'h0} + offset) mod 2^20` and `addr_valid = 1` after that same edge. `addr_valid` is 0 after any edge without a request.
- R3: Kind 0 (instruction fetch) uses the code segment, segment code 0, with `req_offset` as the instruction pointer.
- R4: Kind 1 (stack) uses the stack segment, code 3. A kind 2 data access whose base code is 4 (base pointer) also uses the stack segment.
- R5: A kind 2 data access with any other base code uses the data segment, code 1. These codes are 0 BX, 1 SI, 2 DI and 3 direct displacement. Kind codes 5 to 7 behave as kind 2.
- R6: Kind 3 (string source) uses the data segment with the source index as offset. Kind 4 (string destination) uses the extra segment, code 2, with the destination index as offset. `req_offset` is ignored for both kinds.
- R7: When `ovr_en` is 1, `ovr_sel` replaces the chosen segment for kinds 0 to 3 and 5 to 7. A string destination still uses the extra segment.
- R8: After a string element, only the pointer it used moves. It moves by 1 when `elem_word` is 0 and by 2 when it is 1. It increments when `dir_flag` is 0 and decrements when it is 1, and it wraps within 16 bits.
- R9: An address sum above FFFFFh wraps modulo 2^20.
- R10: A segment write takes effect for requests from the next cycle. A request in the same cycle as the write uses the old base.
- R11: An index load (`idx_wr_en`, `idx_wr_dst` 1 for the destination) in the same cycle as a string step sets the pointer to the loaded value. The address of that element still uses the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Load a segment base |
| seg_wr_sel | input | 2 | Segment to load: 0 code, 1 data, 2 extra, 3 stack |
| seg_wr_data | input | 16 | New segment base |
| idx_wr_en | input | 1 | Load an index pointer |
| idx_wr_dst | input | 1 | 1 loads the destination pointer, 0 the source pointer |
| idx_wr_data | input | 16 | New pointer value |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Access kind: 0 fetch, 1 stack, 2 data, 3 string source, 4 string destination |
| req_base | input | 3 | Base register of a data access: 0 BX, 1 SI, 2 DI, 3 displacement, 4 BP |
| req_offset | input | 16 | Offset for non-string kinds |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| dir_flag | input | 1 | String direction: 0 up, 1 down |
| elem_word | input | 1 | String element size: 0 byte, 1 word |
| addr_valid | output | 1 | Address output valid |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment code used for the address |
| src_idx | output | 16 | Current source index pointer |
| dst_idx | output | 16 | Current destination index pointer |

## Verification
The segment choice is tried with every access kind and every base code, with the four bases set to distinct values so that a wrong pairing shows up in both the address and `seg_used`. The override is applied to a fetch, a base-pointer access and a string destination, which separates an override that is honoured from one that is wrongly applied to the destination. String steps cover both directions and both sizes and end at 0000h and FFFFh, which shows sign and wrap errors in the pointers. Same-cycle segment writes and index loads show whether the design uses old or new values, and a data base near FFFFh shows the 20-bit wrap.

// File: rtl/sag_pkg.sv
// Package: shared codes for the segmented address generator.
// Assumes the four segment codes are used as register indices.
package sag_pkg;
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_id_t;

    typedef enum logic [2:0] {
        ACC_FETCH   = 3'd0,
        ACC_STACK   = 3'd1,
        ACC_DATA    = 3'd2,
        ACC_STR_SRC = 3'd3,
        ACC_STR_DST = 3'd4
    } acc_kind_t;

    typedef enum logic [2:0] {
        BASE_BX   = 3'd0,
        BASE_SI   = 3'd1,
        BASE_DI   = 3'd2,
        BASE_DISP = 3'd3,
        BASE_BP   = 3'd4
    } base_reg_t;

    localparam int NUM_SEG = 4;
endpackage

// File: rtl/sag_seg_regfile.sv
// Segment base register file: one register per segment code, loaded
// through a single write port. Assumes the write select is in range.
module sag_seg_regfile
    import sag_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [1:0]                      wr_sel,
    input  logic [SEG_W-1:0]                wr_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_val
);
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        // Hold one segment base; clear on reset, load on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_val[g] <= '0;
            end else if (wr_en && (wr_sel == 2'(g))) begin
                seg_val[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/sag_seg_select.sv
// Segment choice: applies the default pairing of access kind and base
// register, then the override, which never touches a string destination.
// Unlisted kinds act as data accesses; only the BP base selects stack.
module sag_seg_select
    import sag_pkg::*;
(
    input  logic [2:0] kind,
    input  logic [2:0] base,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    output seg_id_t    seg_sel,
    output logic       use_src,
    output logic       use_dst
);
    acc_kind_t k;
    base_reg_t b;
    seg_id_t   dflt;

    assign k = acc_kind_t'(kind);
    assign b = base_reg_t'(base);

    // Default segment from the access kind and base register.
    always_comb begin
        use_src = 1'b0;
        use_dst = 1'b0;
        case (k)
            ACC_FETCH:   dflt = SEG_CODE;
            ACC_STACK:   dflt = SEG_STACK;
            ACC_STR_SRC: begin
                dflt    = SEG_DATA;
                use_src = 1'b1;
            end
            ACC_STR_DST: begin
                dflt    = SEG_EXTRA;
                use_dst = 1'b1;
            end
            default:     dflt = (b == BASE_BP) ? SEG_STACK : SEG_DATA;
        endcase
    end

    // Override replaces the default except on a string destination.
    always_comb begin
        if (ovr_en && !use_dst) begin
            seg_sel = seg_id_t'(ovr_sel);
        end else begin
            seg_sel = dflt;
        end
    end
endmodule

// File: rtl/sag_str_index.sv
// String index pointers: source and destination offsets that step by the
// element size in the direction given, wrapping in OFF_W bits. A load in
// the same cycle as a step wins.
module sag_str_index #(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_src,
    input  logic             step_dst,
    input  logic             dir_down,
    input  logic             elem_word,
    input  logic             load_en,
    input  logic             load_dst,
    input  logic [OFF_W-1:0] load_data,
    output logic [OFF_W-1:0] src_idx,
    output logic [OFF_W-1:0] dst_idx
);
    logic [OFF_W-1:0] step;
    logic [OFF_W-1:0] src_next;
    logic [OFF_W-1:0] dst_next;

    // Step size and stepped values for both pointers.
    always_comb begin
        step     = elem_word ? OFF_W'(2) : OFF_W'(1);
        src_next = dir_down ? (src_idx - step) : (src_idx + step);
        dst_next = dir_down ? (dst_idx - step) : (dst_idx + step);
    end

    // Source pointer register: load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_idx <= '0;
        end else if (load_en && !load_dst) begin
            src_idx <= load_data;
        end else if (step_src) begin
            src_idx <= src_next;
        end
    end

    // Destination pointer register: load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_idx <= '0;
        end else if (load_en && load_dst) begin
            dst_idx <= load_data;
        end else if (step_dst) begin
            dst_idx <= dst_next;
        end
    end
endmodule

// File: rtl/sag_addr_form.sv
// Address former: appends SHIFT zero bits to the segment base, adds the
// zero-extended offset, keeps ADDR_W bits and registers the result with
// a valid flag. Assumes OFF_W does not exceed ADDR_W.
module sag_addr_form #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SEG_W-1:0]  seg_base,
    input  logic [1:0]        seg_code,
    input  logic [OFF_W-1:0]  offset,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        seg_out
);
    logic [ADDR_W-1:0] sum;

    // Shifted base plus offset, truncated to the address width.
    always_comb begin
        sum = {seg_base, {SHIFT{1'b0}}} + ADDR_W'(offset);
    end

    // Valid flag follows the request strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= req;
        end
    end

    // Capture address and segment code on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            seg_out <= '0;
        end else if (req) begin
            addr    <= sum;
            seg_out <= seg_code;
        end
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Top: real-mode segmented address generator. Holds the segment bases and
// string pointers, picks the segment per request and forms a registered
// 20-bit address one cycle after the strobe.
module seg_addr_gen
    import sag_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              idx_wr_en,
    input  logic              idx_wr_dst,
    input  logic [OFF_W-1:0]  idx_wr_data,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [2:0]        req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_sel,
    input  logic              dir_flag,
    input  logic              elem_word,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_used,
    output logic [OFF_W-1:0]  src_idx,
    output logic [OFF_W-1:0]  dst_idx
);
    logic [NUM_SEG-1:0][SEG_W-1:0] seg_val;
    seg_id_t                       seg_sel;
    logic                          use_src;
    logic                          use_dst;
    logic [OFF_W-1:0]              eff_off;

    sag_seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_val (seg_val)
    );

    sag_seg_select u_sel (
        .kind    (req_kind),
        .base    (req_base),
        .ovr_en  (ovr_en),
        .ovr_sel (ovr_sel),
        .seg_sel (seg_sel),
        .use_src (use_src),
        .use_dst (use_dst)
    );

    sag_str_index #(.OFF_W(OFF_W)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_src  (req_valid && use_src),
        .step_dst  (req_valid && use_dst),
        .dir_down  (dir_flag),
        .elem_word (elem_word),
        .load_en   (idx_wr_en),
        .load_dst  (idx_wr_dst),
        .load_data (idx_wr_data),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx)
    );

    // Offset source: a string pointer or the request offset.
    always_comb begin
        if (use_src) begin
            eff_off = src_idx;
        end else if (use_dst) begin
            eff_off = dst_idx;
        end else begin
            eff_off = req_offset;
        end
    end

    sag_addr_form #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_form (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_valid),
        .seg_base (seg_val[seg_sel]),
        .seg_code (seg_sel),
        .offset   (eff_off),
        .valid    (addr_valid),
        .addr     (phys_addr),
        .seg_out  (seg_used)
    );
endmodule

// File: rtl/sag_checker.sv
// Checker: temporal properties on the ports of seg_addr_gen.
module sag_checker #(
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic             ovr_en,
    input logic [1:0]       ovr_sel,
    input logic             idx_wr_en,
    input logic             dir_flag,
    input logic             elem_word,
    input logic             addr_valid,
    input logic [1:0]       seg_used,
    input logic [OFF_W-1:0] src_idx,
    input logic [OFF_W-1:0] dst_idx
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    p_fetch_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd0 && !ovr_en) |=> seg_used == 2'd0);

    p_dst_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4) |=> seg_used == 2'd2);

    p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_en && req_kind != 3'd4) |=> seg_used == $past(ovr_sel));

    p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !idx_wr_en) |=> ($stable(src_idx) && $stable(dst_idx)));

    p_src_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd3 && !idx_wr_en && !dir_flag)
        |=> src_idx == OFF_W'($past(src_idx) + ($past(elem_word) ? OFF_W'(2) : OFF_W'(1))));

    p_dst_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4 && !idx_wr_en && dir_flag)
        |=> dst_idx == OFF_W'($past(dst_idx) - ($past(elem_word) ? OFF_W'(2) : OFF_W'(1))));
endmodule

bind seg_addr_gen sag_checker #(.OFF_W(OFF_W)) u_sag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .ovr_en     (ovr_en),
    .ovr_sel    (ovr_sel),
    .idx_wr_en  (idx_wr_en),
    .dir_flag   (dir_flag),
    .elem_word  (elem_word),
    .addr_valid (addr_valid),
    .seg_used   (seg_used),
    .src_idx    (src_idx),
    .dst_idx    (dst_idx)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        idx_wr_en = 1'b0;
    logic        idx_wr_dst = 1'b0;
    logic [15:0] idx_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [2:0]  req_base = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        dir_flag = 1'b0;
    logic        elem_word = 1'b0;
    logic        addr_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;
    logic [15:0] src_idx;
    logic [15:0] dst_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_seg [4];
    logic [15:0] m_si = '0;
    logic [15:0] m_di = '0;
    logic [21:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .idx_wr_en(idx_wr_en), .idx_wr_dst(idx_wr_dst), .idx_wr_data(idx_wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
        .req_offset(req_offset), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .dir_flag(dir_flag), .elem_word(elem_word),
        .addr_valid(addr_valid), .phys_addr(phys_addr), .seg_used(seg_used),
        .src_idx(src_idx), .dst_idx(dst_idx)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: issue one request, push the expected result
    task automatic req(input logic [2:0] k, input logic [2:0] b, input logic [15:0] off,
                       input logic oe, input logic [1:0] os, input logic d,
                       input logic w, input string tag);
        logic [1:0]  s;
        logic [15:0] o;
        logic [15:0] st;
        @(negedge clk);
        st = w ? 16'd2 : 16'd1;
        o  = off;
        case (k)
            3'd0: s = 2'd0;
            3'd1: s = 2'd3;
            3'd3: begin s = 2'd1; o = m_si; end
            3'd4: begin s = 2'd2; o = m_di; end
            default: s = (b == 3'd4) ? 2'd3 : 2'd1;
        endcase
        if (oe && k != 3'd4) s = os;
        exp_q.push_back({s, 20'({m_seg[s], 4'h0} + {4'h0, o})});
        tag_q.push_back(tag);
        if (k == 3'd3) m_si = d ? m_si - st : m_si + st;
        if (k == 3'd4) m_di = d ? m_di - st : m_di + st;
        req_valid = 1'b1; req_kind = k; req_base = b; req_offset = off;
        ovr_en = oe; ovr_sel = os; dir_flag = d; elem_word = w;
    endtask

    // Drive a segment write in the current cycle (no wait)
    task automatic seg_now(input logic [1:0] s, input logic [15:0] v);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v; m_seg[s] = v;
    endtask

    task automatic idx_now(input logic dst, input logic [15:0] v);
        idx_wr_en = 1'b1; idx_wr_dst = dst; idx_wr_data = v;
        if (dst) m_di = v; else m_si = v;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; seg_wr_en = 1'b0; idx_wr_en = 1'b0; ovr_en = 1'b0;
    endtask

    task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        seg_now(s, v);
        idle();
    endtask

    task automatic wr_idx(input logic dst, input logic [15:0] v);
        @(negedge clk);
        idx_now(dst, v);
        idle();
    endtask

    task automatic chk_idx(input string tag);
        chk(src_idx == m_si, {tag, " src"}, 32'(src_idx), 32'(m_si));
        chk(dst_idx == m_di, {tag, " dst"}, 32'(dst_idx), 32'(m_di));
    endtask

    // Monitor: pop and compare whenever the design presents an address
    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected valid", 32'(phys_addr), 32'h0);
            end else begin
                logic [21:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({seg_used, phys_addr} == e, t, 32'({seg_used, phys_addr}), 32'(e));
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_seg[i] = '0;
        repeat (3) @(negedge clk);
        chk(addr_valid == 1'b0, "R1 valid after reset", 32'(addr_valid), 32'h0);
        chk_idx("R1 reset pointers");
        rst_n = 1'b1;
        req(3'd2, 3'd0, 16'h1234, 1'b0, 2'd0, 1'b0, 1'b0, "R1 zero base");
        idle();
        chk(addr_valid == 1'b1, "R2 valid after request", 32'(addr_valid), 32'h1);
        idle();
        chk(addr_valid == 1'b0, "R2 valid drops", 32'(addr_valid), 32'h0);

        wr_seg(2'd0, 16'h1400);
        wr_seg(2'd1, 16'h1000);
        wr_seg(2'd2, 16'h2100);
        wr_seg(2'd3, 16'h2000);

        req(3'd0, 3'd0, 16'h1200, 1'b0, 2'd0, 1'b0, 1'b0, "R3 fetch");
        req(3'd1, 3'd0, 16'h0FFE, 1'b0, 2'd0, 1'b0, 1'b0, "R4 stack");
        req(3'd2, 3'd4, 16'h3000, 1'b0, 2'd0, 1'b0, 1'b0, "R4 bp base");
        req(3'd2, 3'd0, 16'h0010, 1'b0, 2'd0, 1'b0, 1'b0, "R5 bx base");
        req(3'd2, 3'd1, 16'h0020, 1'b0, 2'd0, 1'b0, 1'b0, "R5 si base");
        req(3'd2, 3'd2, 16'h0030, 1'b0, 2'd0, 1'b0, 1'b0, "R5 di base");
        req(3'd2, 3'd3, 16'hFFFF, 1'b0, 2'd0, 1'b0, 1'b0, "R5 displacement");
        req(3'd6, 3'd0, 16'h0040, 1'b0, 2'd0, 1'b0, 1'b0, "R5 spare kind");
        req(3'd0, 3'd0, 16'h0008, 1'b1, 2'd2, 1'b0, 1'b0, "R7 fetch override");
        req(3'd2, 3'd4, 16'h0100, 1'b1, 2'd1, 1'b0, 1'b0, "R7 bp override");
        req(3'd4, 3'd0, 16'h0000, 1'b1, 2'd0, 1'b0, 1'b0, "R7 dest ignores override");
        idle();
        chk_idx("R8 dest after override");

        wr_idx(1'b0, 16'h0010);
        wr_idx(1'b1, 16'hFFFF);
        req(3'd3, 3'd0, 16'hAAAA, 1'b0, 2'd0, 1'b0, 1'b0, "R6 source byte up");
        idle();
        chk_idx("R8 source up by 1");
        req(3'd3, 3'd0, 16'h5555, 1'b0, 2'd0, 1'b1, 1'b1, "R6 source word down");
        idle();
        chk_idx("R8 source down by 2");
        req(3'd4, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R6 dest byte up");
        idle();
        chk_idx("R8 dest wraps to 0");
        req(3'd4, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b1, "R6 dest word down");
        idle();
        chk_idx("R8 dest wraps below 0");
        req(3'd3, 3'd0, 16'h0000, 1'b1, 2'd3, 1'b0, 1'b1, "R7 source override");
        idle();
        chk_idx("R8 source word up");

        wr_seg(2'd1, 16'hFFFF);
        req(3'd2, 3'd3, 16'h0020, 1'b0, 2'd0, 1'b0, 1'b0, "R9 wrap past 1MB");
        req(3'd2, 3'd3, 16'h0005, 1'b0, 2'd0, 1'b0, 1'b0, "R10 old base same cycle");
        seg_now(2'd1, 16'h3000);
        req(3'd2, 3'd3, 16'h0005, 1'b0, 2'd0, 1'b0, 1'b0, "R10 new base next cycle");
        seg_wr_en = 1'b0;
        req(3'd3, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R11 old pointer used");
        idx_now(1'b0, 16'h0100);
        idle();
        chk_idx("R11 load wins over step");
        req(3'd3, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, "R11 loaded pointer");
        idle();
        repeat (3) idle();
        chk(exp_q.size() == 0, "R2 all results seen", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule